// File: doc/BRIEF.md
# Cycle Threshold Timer with Elapsed-Branch Resolution

This block is a timer that a small in-order processor drives with two dedicated instructions rather than through memory-mapped registers. The timer-start instruction carries an unsigned immediate. When the decoder sees that instruction it pulses a start strobe, and the timer takes the immediate as its limit, clears its count and begins counting. From then on the count advances by one on every clock edge. When the count equals the limit, counting stops, a registered reached flag goes high, and both stay as they are until the next start.

The branch-on-elapsed instruction is resolved against that flag. If the branch is presented while the flag is high, the block requests a redirect of the PC to the branch's absolute target. If the flag is low, no redirect is requested and execution falls through to the next instruction. Software turns wanted delays into cycle counts from the fixed clock frequency. Opcode decode belongs to the processor. In the processor's encoding, 10111 is the timer-start opcode and 11000 is the branch-on-elapsed opcode, both in jump-immediate format. This block only sees the already-decoded strobes.

Top module: `cyc_timer`

## Requirements
- R1: After reset, and until the first start strobe, reached_o is 0, count_o is 0 and take_o is 0.
- R2: On the clock edge where start_i is 1, thresh_i is latched as the limit and the count is cleared. In the following cycle count_o reads 0.
- R3: After a start with a nonzero limit T, count_o reads k after k further clock edges, for every k from 0 to T, with no start in between.
- R4: reached_o rises on the same edge that brings count_o to the limit. After that, count_o and reached_o hold their values for as long as no start arrives.
- R5: A limit of 0 makes reached_o 1 in the cycle right after the start strobe, with count_o at 0.
- R6: A start that arrives while counting clears the count to 0 and replaces the limit. The new limit alone decides when reached_o rises.
- R7: A start that arrives after the limit was reached clears reached_o, unless the new limit is 0, and counting begins again.
- R8: take_o is 1, and target_o equals br_target_i, exactly when br_valid_i and reached_o are both 1 in the same cycle. Otherwise take_o is 0 and the branch falls through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Decoded timer-start strobe |
| thresh_i | input | CNT_W (27) | Limit immediate of the start instruction |
| br_valid_i | input | 1 | Decoded branch-on-elapsed strobe |
| br_target_i | input | PC_W (27) | Absolute target of the branch |
| reached_o | output | 1 | Registered flag: count has met the limit |
| count_o | output | CNT_W (27) | Current count |
| take_o | output | 1 | Redirect request for the PC |
| target_o | output | PC_W (27) | Redirect address, valid while take_o is 1 |

## Verification
The bench targets the off-by-one edges first. It checks that the flag rises exactly T edges after the start edge. An early compare, or a flag fed by an extra register, would shift that by a cycle. It also checks that a limit of zero is reached at once rather than after a wrap through the full count range. Restarts are exercised both mid-count and after expiry: a design that fails to clear the count, or that keeps a stale flag high, would let a following branch be taken too early. It also holds a reached timer for many cycles to catch a count that creeps past the limit, and it presents branches while the timer is idle, counting and expired to catch a redirect that ignores the flag.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
    localparam int unsigned DEF_CNT_W = 27;
    localparam int unsigned DEF_PC_W  = 27;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } tmr_phase_e;
endpackage

// File: rtl/cyc_timer_core.sv
module cyc_timer_core
    import cyc_timer_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             reached_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        tmr_phase_e       phase;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] limit;
    } tmr_state_t;

    tmr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.count = '0;
            s_d.limit = thresh_i;
            s_d.phase = (thresh_i == '0) ? PH_DONE : PH_RUN;
        end else if (s_q.phase == PH_RUN) begin
            s_d.count = s_q.count + ONE;
            if (s_d.count == s_q.limit) begin
                s_d.phase = PH_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, count: '0, limit: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign reached_o = (s_q.phase == PH_DONE);
    assign count_o   = s_q.count;
endmodule

// File: rtl/cyc_timer_branch.sv
module cyc_timer_branch #(
    parameter int unsigned PC_W = cyc_timer_pkg::DEF_PC_W
) (
    input  logic            br_valid_i,
    input  logic [PC_W-1:0] br_target_i,
    input  logic            reached_i,
    output logic            take_o,
    output logic [PC_W-1:0] target_o
);
    always_comb begin
        take_o   = br_valid_i & reached_i;
        target_o = take_o ? br_target_i : '0;
    end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
    import cyc_timer_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W,
    parameter int unsigned PC_W  = DEF_PC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             br_valid_i,
    input  logic [PC_W-1:0]  br_target_i,
    output logic             reached_o,
    output logic [CNT_W-1:0] count_o,
    output logic             take_o,
    output logic [PC_W-1:0]  target_o
);
    cyc_timer_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .thresh_i  (thresh_i),
        .reached_o (reached_o),
        .count_o   (count_o)
    );

    cyc_timer_branch #(.PC_W(PC_W)) i_branch (
        .br_valid_i  (br_valid_i),
        .br_target_i (br_target_i),
        .reached_i   (reached_o),
        .take_o      (take_o),
        .target_o    (target_o)
    );
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
    parameter int unsigned CNT_W = 27,
    parameter int unsigned PC_W  = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] thresh_i,
    input logic             br_valid_i,
    input logic [PC_W-1:0]  br_target_i,
    input logic             reached_o,
    input logic [CNT_W-1:0] count_o,
    input logic             take_o,
    input logic [PC_W-1:0]  target_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (start_i) seen_q <= 1'b1;
    end

    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!reached_o && count_o == '0 && !take_o));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> count_o == '0);

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !start_i && !reached_o) |=> count_o == $past(count_o) + ONE);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reached_o && !start_i) |=> (reached_o && $stable(count_o)));

    a_r5_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && thresh_i == '0) |=> reached_o);

    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && thresh_i != '0) |=> !reached_o);

    a_r8_take_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (reached_o && br_valid_i));

    a_r8_take_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && reached_o) |-> (take_o && target_o == br_target_i));
endmodule

bind cyc_timer cyc_timer_chk #(.CNT_W(CNT_W), .PC_W(PC_W)) i_chk (.*);

// File: tb/test_cyc_timer.sv
`timescale 1ns/1ps
module test_cyc_timer;
    localparam int CNT_W = 27;
    localparam int PC_W  = 27;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] thresh_i = '0;
    logic             br_valid_i = 1'b0;
    logic [PC_W-1:0]  br_target_i = '0;
    logic             reached_o;
    logic [CNT_W-1:0] count_o;
    logic             take_o;
    logic [PC_W-1:0]  target_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cyc_timer #(.CNT_W(CNT_W), .PC_W(PC_W)) i_cyc_timer (.*);

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pulse start for one edge; returns at the negedge after that edge.
    task automatic do_start(input int t);
        @(negedge clk);
        start_i  = 1'b1;
        thresh_i = CNT_W'(t);
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "reached after reset", reached_o, 0);
        check("R1", "count after reset", count_o, 0);
        wait_edges(4);
        check("R1", "count while idle", count_o, 0);
        br_valid_i = 1'b1; br_target_i = 27'd123; #1;
        check("R1", "take while idle", take_o, 0);
        br_valid_i = 1'b0;
    endtask

    task automatic t_count(input int t);
        do_start(t);
        check("R2", "count right after start", count_o, 0);
        for (int k = 1; k <= t; k++) begin
            check("R4", "reached before limit", reached_o, 0);
            @(negedge clk);
            check("R3", "count step", count_o, k);
        end
        check("R4", "reached at limit", reached_o, 1);
        wait_edges(10);
        check("R4", "count held", count_o, t);
        check("R4", "reached held", reached_o, 1);
    endtask

    task automatic t_zero;
        do_start(0);
        check("R5", "reached for zero limit", reached_o, 1);
        check("R5", "count for zero limit", count_o, 0);
        wait_edges(3);
        check("R5", "count stays zero", count_o, 0);
    endtask

    task automatic t_restart_mid;
        do_start(20);
        wait_edges(7);
        check("R6", "count before restart", count_o, 7);
        do_start(3);
        check("R6", "count cleared by restart", count_o, 0);
        check("R6", "flag low after restart", reached_o, 0);
        wait_edges(2);
        check("R6", "not yet reached", reached_o, 0);
        wait_edges(1);
        check("R6", "reached at new limit", reached_o, 1);
        check("R6", "count at new limit", count_o, 3);
    endtask

    task automatic t_restart_done;
        do_start(2);
        wait_edges(2);
        check("R7", "reached before restart", reached_o, 1);
        do_start(4);
        check("R7", "flag cleared by restart", reached_o, 0);
        wait_edges(2);
        check("R7", "counting again", count_o, 2);
        do_start(0);
        check("R7", "zero restart keeps flag", reached_o, 1);
    endtask

    task automatic t_branch;
        do_start(5);
        wait_edges(2);
        br_valid_i = 1'b1; br_target_i = 27'h1234; #1;
        check("R8", "falls through while counting", take_o, 0);
        br_valid_i = 1'b0;
        wait_edges(3);
        br_valid_i = 1'b1; br_target_i = 27'h5a5a5; #1;
        check("R8", "taken when reached", take_o, 1);
        check("R8", "target when taken", target_o, 27'h5a5a5);
        br_valid_i = 1'b0; #1;
        check("R8", "no take without branch", take_o, 0);
    endtask

    initial begin
        #12 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count(5);
        t_count(1);
        t_zero();
        t_restart_mid();
        t_restart_done();
        t_branch();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule